// File: doc/BRIEF.md
# SATA Port Command Slot Tracker

This block tracks the command slots of one SATA host-controller port. It holds two slot registers. The issue register has one bit per slot that software sets to hand a command to the port. The active-queue register has one bit per native-queued command still outstanding at the device. While the port is started, the block hands pending slots one at a time to a single command engine, always taking the lowest-numbered pending slot first. It then clears slot bits according to how the command ended.

A non-queued command keeps its issue bit until it completes cleanly. A queued command drops its issue bit as soon as the engine accepts it cleanly, and drops its active-queue bit when it completes without error. Any error stops further dispatch. Software recovers by clearing the start bit, which empties both registers, and then setting it again.

The control is a five-state machine:
- **IDLE**: the port is stopped.
- **SCAN**: looks for a pending slot.
- **ISSUE**: presents the dispatch request until the engine acknowledges it.
- **NQ_BUSY**: waits for a non-queued command to complete.
- **HALT**: holds off dispatch after an error.

Transitions:
- IDLE→SCAN when the start bit is set.
- SCAN→ISSUE when a slot is pending and the engine is neither busy nor requesting data.
- SCAN→IDLE when the start bit is clear.
- ISSUE→NQ_BUSY on a non-queued acknowledge.
- ISSUE→SCAN on a clean queued acknowledge.
- ISSUE→HALT on a queued acknowledge with error status.
- NQ_BUSY→SCAN on a completion without error.
- NQ_BUSY→HALT on a completion with error.
- Any running state→HALT on a queued completion with error.
- Any state→IDLE when the start bit falls.

Top module: `slot_trk`

## Requirements
- R1: After reset the issue and active-queue registers read 0, the start and running bits read 0, `disp_vld` is 0, and `nq_tag_o` reads all ones (63, the "no non-queued command" marker).
- R2: A write to either register ORs its data into that register. Bits are never cleared by a write, and writing 0 changes nothing.
- R3: Writing 0 to the start bit while it reads 1 clears both registers to 0 on the next cycle. Writing 0 while it already reads 0 has no effect on them.
- R4: `running_o` equals the start bit delayed by one clock, so it drops one cycle after the start bit is cleared.
- R5: While started, pending slots are dispatched lowest number first, one at a time. `disp_vld` is high with `disp_slot` holding the slot number until `eng_ack`.
- R6: No dispatch begins in a cycle in which `tf_bsy` or `tf_drq` is 1. The slot stays pending and is taken later.
- R7: A non-queued command (acknowledged with `eng_queued`=0) keeps its issue bit until `nq_done`. The bit is cleared then only if `tf_err`, `tf_bsy` and `tf_drq` are all 0. `nq_tag_o` holds the slot number exactly while such a command is outstanding and reads 63 otherwise.
- R8: A queued command (acknowledged with `eng_queued`=1) has its issue bit cleared at the acknowledge if `tf_err`, `tf_bsy` and `tf_drq` are all 0. Otherwise the bit stays set.
- R9: A `q_done` with `tf_err`=0 clears the active-queue bit numbered by `q_done_slot`. With `tf_err`=1 that bit stays set.
- R10: After an error (a completion or queued acknowledge with `tf_err`=1), nothing is dispatched until the start bit is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Write strobe for the start bit |
| start_val | input | 1 | Value written to the start bit |
| ci_set_vld | input | 1 | Write strobe for the issue register |
| ci_set_bits | input | 32 | Bits ORed into the issue register |
| sa_set_vld | input | 1 | Write strobe for the active-queue register |
| sa_set_bits | input | 32 | Bits ORed into the active-queue register |
| tf_err | input | 1 | Task-file error status |
| tf_bsy | input | 1 | Task-file busy status |
| tf_drq | input | 1 | Task-file data-request status |
| eng_ack | input | 1 | Engine takes the presented slot |
| eng_queued | input | 1 | The acknowledged command is native-queued |
| nq_done | input | 1 | Non-queued command completion |
| q_done | input | 1 | Queued command completion |
| q_done_slot | input | 5 | Slot of the queued completion |
| disp_vld | output | 1 | Dispatch request |
| disp_slot | output | 5 | Slot being dispatched |
| ci_o | output | 32 | Issue register |
| sact_o | output | 32 | Active-queue register |
| start_o | output | 1 | Start bit |
| running_o | output | 1 | Command-running status |
| nq_tag_o | output | 6 | Outstanding non-queued slot, 63 when none |

## Verification
The assertions assume that the status bits sampled in a completion or acknowledge cycle are the final status of that command. They also assume that `nq_done` comes only while a non-queued command is outstanding, and that `q_done_slot` names a slot the engine really queued. The stimulus changes inputs only on falling edges and pulses each event for exactly one cycle. It raises `nq_done` only one cycle or more after the dispatch it answers, and holds `tf_err` high only during the event it qualifies.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SCAN    = 3'd1,
        ST_ISSUE   = 3'd2,
        ST_NQ_BUSY = 3'd3,
        ST_HALT    = 3'd4
    } trk_state_e;
endpackage

// File: rtl/slot_trk_pick.sv
module slot_trk_pick #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] pend,
    output logic                 found,
    output logic [SLOT_W-1:0]    idx
);
    logic [NUM_SLOTS:0]   seen;
    logic [NUM_SLOTS-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pick
        assign seen[i+1] = seen[i] | pend[i];
        assign first[i]  = pend[i] & ~seen[i];
    end

    assign found = seen[NUM_SLOTS];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (first[i]) begin
                idx = idx | SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/slot_trk_bits.sv
module slot_trk_bits #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 set_vld,
    input  logic [NUM_SLOTS-1:0] set_bits,
    input  logic [NUM_SLOTS-1:0] clr_mask,
    output logic [NUM_SLOTS-1:0] q
);
    logic [NUM_SLOTS-1:0] set_eff;

    assign set_eff = set_vld ? set_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (flush) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_mask) | set_eff;
        end
    end
endmodule

// File: rtl/slot_trk_fsm.sv
module slot_trk_fsm
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int TAG_W  = SLOT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_q,
    input  logic                 flush,
    input  logic                 pick_found,
    input  logic [SLOT_W-1:0]    pick_idx,
    input  logic                 tf_err,
    input  logic                 tf_bsy,
    input  logic                 tf_drq,
    input  logic                 eng_ack,
    input  logic                 eng_queued,
    input  logic                 nq_done,
    input  logic                 q_done,
    input  logic [SLOT_W-1:0]    q_done_slot,
    output trk_state_e           state_o,
    output logic                 disp_vld,
    output logic [SLOT_W-1:0]    disp_slot,
    output logic [TAG_W-1:0]     nq_tag,
    output logic [NUM_SLOTS-1:0] ci_clr,
    output logic [NUM_SLOTS-1:0] sa_clr
);
    localparam logic [TAG_W-1:0] NQ_NONE = '1;

    trk_state_e          state_q, state_d;
    logic [SLOT_W-1:0]   slot_q, slot_d;
    logic [TAG_W-1:0]    tag_q, tag_d;
    logic                clean;

    assign clean = !tf_err && !tf_bsy && !tf_drq;

    // next state
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (st_q) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (!st_q) begin
                    state_d = ST_IDLE;
                end else if (pick_found && !tf_bsy && !tf_drq) begin
                    state_d = ST_ISSUE;
                    slot_d  = pick_idx;
                end
            end
            ST_ISSUE: begin
                if (eng_ack) begin
                    if (eng_queued) state_d = tf_err ? ST_HALT : ST_SCAN;
                    else            state_d = ST_NQ_BUSY;
                end
            end
            ST_NQ_BUSY: begin
                if (nq_done) state_d = tf_err ? ST_HALT : ST_SCAN;
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_IDLE;
        endcase
        if (q_done && tf_err && state_q != ST_IDLE) state_d = ST_HALT;
        if (flush) state_d = ST_IDLE;
    end

    always_comb begin
        if (state_d == ST_NQ_BUSY) begin
            tag_d = (state_q == ST_NQ_BUSY) ? tag_q : {1'b0, slot_q};
        end else begin
            tag_d = NQ_NONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            tag_q   <= NQ_NONE;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            tag_q   <= tag_d;
        end
    end

    // outputs
    always_comb begin
        disp_vld  = (state_q == ST_ISSUE);
        disp_slot = slot_q;
        nq_tag    = tag_q;
        state_o   = state_q;
        ci_clr    = '0;
        sa_clr    = '0;
        if (state_q == ST_ISSUE && eng_ack && eng_queued && clean) begin
            ci_clr = NUM_SLOTS'(1) << slot_q;
        end
        if (state_q == ST_NQ_BUSY && nq_done && clean) begin
            ci_clr = NUM_SLOTS'(1) << tag_q[SLOT_W-1:0];
        end
        if (q_done && !tf_err) begin
            sa_clr = NUM_SLOTS'(1) << q_done_slot;
        end
    end
endmodule

// File: rtl/slot_trk.sv
module slot_trk
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int TAG_W  = SLOT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_wr,
    input  logic                 start_val,
    input  logic                 ci_set_vld,
    input  logic [NUM_SLOTS-1:0] ci_set_bits,
    input  logic                 sa_set_vld,
    input  logic [NUM_SLOTS-1:0] sa_set_bits,
    input  logic                 tf_err,
    input  logic                 tf_bsy,
    input  logic                 tf_drq,
    input  logic                 eng_ack,
    input  logic                 eng_queued,
    input  logic                 nq_done,
    input  logic                 q_done,
    input  logic [SLOT_W-1:0]    q_done_slot,
    output logic                 disp_vld,
    output logic [SLOT_W-1:0]    disp_slot,
    output logic [NUM_SLOTS-1:0] ci_o,
    output logic [NUM_SLOTS-1:0] sact_o,
    output logic                 start_o,
    output logic                 running_o,
    output logic [TAG_W-1:0]     nq_tag_o
);
    logic                 st_q;
    logic                 run_q;
    logic                 flush_evt;
    logic                 pick_found;
    logic [SLOT_W-1:0]    pick_idx;
    logic [NUM_SLOTS-1:0] ci_clr;
    logic [NUM_SLOTS-1:0] sa_clr;
    trk_state_e           run_state;

    assign flush_evt = start_wr && !start_val && st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            run_q <= st_q;
            if (start_wr) st_q <= start_val;
        end
    end

    slot_trk_bits #(.NUM_SLOTS(NUM_SLOTS)) u_ci (
        .clk(clk), .rst_n(rst_n), .flush(flush_evt),
        .set_vld(ci_set_vld), .set_bits(ci_set_bits),
        .clr_mask(ci_clr), .q(ci_o)
    );

    slot_trk_bits #(.NUM_SLOTS(NUM_SLOTS)) u_sa (
        .clk(clk), .rst_n(rst_n), .flush(flush_evt),
        .set_vld(sa_set_vld), .set_bits(sa_set_bits),
        .clr_mask(sa_clr), .q(sact_o)
    );

    slot_trk_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .pend(ci_o), .found(pick_found), .idx(pick_idx)
    );

    slot_trk_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .flush(flush_evt),
        .pick_found(pick_found), .pick_idx(pick_idx),
        .tf_err(tf_err), .tf_bsy(tf_bsy), .tf_drq(tf_drq),
        .eng_ack(eng_ack), .eng_queued(eng_queued),
        .nq_done(nq_done), .q_done(q_done), .q_done_slot(q_done_slot),
        .state_o(run_state), .disp_vld(disp_vld), .disp_slot(disp_slot),
        .nq_tag(nq_tag_o), .ci_clr(ci_clr), .sa_clr(sa_clr)
    );

    assign start_o   = st_q;
    assign running_o = run_q;
endmodule

// File: rtl/slot_trk_chk.sv
module slot_trk_chk
    import slot_trk_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int TAG_W  = SLOT_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_wr,
    input logic                 start_val,
    input logic                 st_q,
    input logic                 flush_evt,
    input logic                 running_o,
    input logic                 tf_err,
    input logic                 tf_bsy,
    input logic                 tf_drq,
    input logic                 disp_vld,
    input logic                 q_done,
    input logic [SLOT_W-1:0]    q_done_slot,
    input logic [NUM_SLOTS-1:0] ci_o,
    input logic [NUM_SLOTS-1:0] sact_o,
    input logic [TAG_W-1:0]     nq_tag_o,
    input trk_state_e           run_state
);
    localparam logic [TAG_W-1:0] NQ_NONE = '1;

    // R3
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !start_val && st_q) |=> (ci_o == '0 && sact_o == '0));

    // R4
    running_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (running_o == $past(st_q)));

    // R6
    no_disp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_vld) |-> (!$past(tf_bsy) && !$past(tf_drq)));

    // R7
    nq_tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((run_state == ST_NQ_BUSY) == (nq_tag_o != NQ_NONE)));

    // R9
    q_err_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_done && tf_err && sact_o[q_done_slot] && !flush_evt)
        |=> sact_o[$past(q_done_slot)]);

    // R10
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_done && tf_err && run_state != ST_IDLE && !flush_evt)
        |=> (run_state == ST_HALT && !disp_vld));
endmodule

bind slot_trk slot_trk_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_val(start_val),
    .st_q(st_q), .flush_evt(flush_evt), .running_o(running_o),
    .tf_err(tf_err), .tf_bsy(tf_bsy), .tf_drq(tf_drq),
    .disp_vld(disp_vld), .q_done(q_done), .q_done_slot(q_done_slot),
    .ci_o(ci_o), .sact_o(sact_o), .nq_tag_o(nq_tag_o), .run_state(run_state)
);

// File: tb/slot_trk_bench.sv
module slot_trk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 1'b0, start_val = 1'b0;
    logic        ci_set_vld = 1'b0, sa_set_vld = 1'b0;
    logic [31:0] ci_set_bits = '0, sa_set_bits = '0;
    logic        tf_err = 1'b0, tf_bsy = 1'b0, tf_drq = 1'b0;
    logic        eng_ack = 1'b1, eng_queued = 1'b0;
    logic        nq_done = 1'b0, q_done = 1'b0;
    logic [4:0]  q_done_slot = '0;
    logic        disp_vld;
    logic [4:0]  disp_slot;
    logic [31:0] ci_o, sact_o;
    logic        start_o, running_o;
    logic [5:0]  nq_tag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slot_trk u_slot_trk (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_val(start_val),
        .ci_set_vld(ci_set_vld), .ci_set_bits(ci_set_bits),
        .sa_set_vld(sa_set_vld), .sa_set_bits(sa_set_bits),
        .tf_err(tf_err), .tf_bsy(tf_bsy), .tf_drq(tf_drq),
        .eng_ack(eng_ack), .eng_queued(eng_queued),
        .nq_done(nq_done), .q_done(q_done), .q_done_slot(q_done_slot),
        .disp_vld(disp_vld), .disp_slot(disp_slot), .ci_o(ci_o),
        .sact_o(sact_o), .start_o(start_o), .running_o(running_o),
        .nq_tag_o(nq_tag_o)
    );

    // behavioural reference: phase 0 stopped, 1 looking, 2 offering, 3 waiting, 4 stuck
    int          m_ph;
    int          m_slot;
    int          m_tag;
    logic [31:0] m_ci, m_sa;
    logic        m_st, m_run;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_slot = 0; m_tag = 63;
            m_ci = '0; m_sa = '0; m_st = 1'b0; m_run = 1'b0;
        end else begin
            bit          fl, ok;
            int          nx, low;
            logic [31:0] cc, sc;
            fl = start_wr && !start_val && m_st;
            ok = !tf_err && !tf_bsy && !tf_drq;
            cc = '0; sc = '0; nx = m_ph; low = -1;
            for (int i = 31; i >= 0; i--) if (m_ci[i]) low = i;
            case (m_ph)
                0: if (m_st) nx = 1;
                1: if (!m_st) nx = 0;
                   else if (low >= 0 && !tf_bsy && !tf_drq) begin nx = 2; m_slot = low; end
                2: if (eng_ack) begin
                       if (eng_queued) begin
                           if (ok) cc[m_slot] = 1'b1;
                           nx = tf_err ? 4 : 1;
                       end else nx = 3;
                   end
                3: if (nq_done) begin
                       if (ok) cc[m_tag] = 1'b1;
                       nx = tf_err ? 4 : 1;
                   end
                default: ;
            endcase
            if (q_done && !tf_err) sc[q_done_slot] = 1'b1;
            if (q_done && tf_err && m_ph != 0) nx = 4;
            if (fl) nx = 0;
            m_tag = (nx == 3) ? ((m_ph == 3) ? m_tag : m_slot) : 63;
            if (fl) begin
                m_ci = '0; m_sa = '0;
            end else begin
                m_ci = (m_ci & ~cc) | (ci_set_vld ? ci_set_bits : 32'h0);
                m_sa = (m_sa & ~sc) | (sa_set_vld ? sa_set_bits : 32'h0);
            end
            m_run = m_st;
            if (start_wr) m_st = start_val;
            m_ph = nx;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (disp_vld !== (m_ph == 2) || (disp_vld && disp_slot !== 5'(m_slot)) ||
                ci_o !== m_ci || sact_o !== m_sa || start_o !== m_st ||
                running_o !== m_run || nq_tag_o !== 6'(m_tag)) begin
                fails++;
                $display("FAIL model R5/R7/R8 act disp=%0b/%0d ci=%h sa=%h tag=%0d exp disp=%0b/%0d ci=%h sa=%h tag=%0d",
                         disp_vld, disp_slot, ci_o, sact_o, nq_tag_o,
                         (m_ph == 2), m_slot, m_ci, m_sa, m_tag);
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ci(logic [31:0] b);
        ci_set_bits = b; ci_set_vld = 1'b1; tick(1); ci_set_vld = 1'b0;
    endtask

    task automatic pulse_sa(logic [31:0] b);
        sa_set_bits = b; sa_set_vld = 1'b1; tick(1); sa_set_vld = 1'b0;
    endtask

    task automatic write_start(logic v);
        start_val = v; start_wr = 1'b1; tick(1); start_wr = 1'b0;
    endtask

    task automatic pulse_nq(logic err);
        tf_err = err; nq_done = 1'b1; tick(1); nq_done = 1'b0; tf_err = 1'b0;
    endtask

    task automatic pulse_q(logic [4:0] s, logic err);
        q_done_slot = s; tf_err = err; q_done = 1'b1; tick(1);
        q_done = 1'b0; tf_err = 1'b0;
    endtask

    task automatic wait_disp(string req, int exp);
        int n = 0;
        while (!disp_vld && n < 30) begin tick(1); n++; end
        chk(req, disp_vld ? disp_slot : 6'h3f, exp);
    endtask

    task automatic no_disp(string req, int n);
        for (int i = 0; i < n; i++) begin
            chk(req, disp_vld, 0);
            tick(1);
        end
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 ci", ci_o, 0);
        chk("R1 sact", sact_o, 0);
        chk("R1 start", start_o, 0);
        chk("R1 running", running_o, 0);
        chk("R1 disp", disp_vld, 0);
        chk("R1 tag", nq_tag_o, 63);

        // R2 OR-only writes
        pulse_ci(32'h5); chk("R2 ci first", ci_o, 32'h5);
        pulse_ci(32'h2); chk("R2 ci or", ci_o, 32'h7);
        pulse_sa(32'h10); pulse_sa(32'h1); chk("R2 sact or", sact_o, 32'h11);
        pulse_sa(32'h0); chk("R2 sact zero write", sact_o, 32'h11);
        chk("R5 no dispatch while stopped", disp_vld, 0);

        // R3 clearing an already clear start bit
        write_start(1'b0);
        chk("R3 ci kept", ci_o, 32'h7);
        chk("R3 sact kept", sact_o, 32'h11);

        // R4 and R6
        tf_bsy = 1'b1;
        write_start(1'b1);
        chk("R4 start set", start_o, 1);
        chk("R4 running lags", running_o, 0);
        tick(1);
        chk("R4 running set", running_o, 1);
        no_disp("R6 busy blocks", 5);
        tf_bsy = 1'b0; tf_drq = 1'b1;
        no_disp("R6 drq blocks", 4);
        chk("R6 ci pending", ci_o, 32'h7);
        tf_drq = 1'b0;

        // R5 and R7 non-queued clean
        wait_disp("R5 lowest first", 0);
        tf_bsy = 1'b1;
        tick(1);
        chk("R7 tag held", nq_tag_o, 0);
        tick(2);
        chk("R7 ci kept while busy", ci_o, 32'h7);
        tf_bsy = 1'b0;
        pulse_nq(1'b0);
        chk("R7 cleared on clean done", ci_o, 32'h6);
        chk("R7 tag released", nq_tag_o, 63);

        // R7 completion with drq still set keeps the bit, then retry
        wait_disp("R5 next slot", 1);
        tf_drq = 1'b1;
        tick(1);
        pulse_nq(1'b0);
        chk("R7 drq keeps bit", ci_o, 32'h6);
        tf_drq = 1'b0;
        wait_disp("R6 retry slot", 1);
        tick(1);
        eng_queued = 1'b1;
        pulse_nq(1'b0);
        chk("R7 retry cleared", ci_o, 32'h4);

        // R8 and R9 queued
        wait_disp("R5 queued slot", 2);
        tick(1);
        chk("R8 cleared on accept", ci_o, 32'h0);
        chk("R7 no tag for queued", nq_tag_o, 63);
        pulse_sa(32'h4);
        chk("R2 sact add", sact_o, 32'h15);
        pulse_q(5'd2, 1'b0);
        chk("R9 clean done clears", sact_o, 32'h11);
        pulse_q(5'd4, 1'b1);
        chk("R9 error done keeps", sact_o, 32'h11);

        // R10 halted
        pulse_ci(32'h100);
        no_disp("R10 halted", 8);
        chk("R10 ci pending", ci_o, 32'h100);
        write_start(1'b0);
        chk("R3 flush ci", ci_o, 0);
        chk("R3 flush sact", sact_o, 0);
        chk("R4 running one more cycle", running_o, 1);
        tick(1);
        chk("R4 running dropped", running_o, 0);

        // R10 recovery, then non-queued error
        eng_queued = 1'b0;
        write_start(1'b1);
        pulse_ci(32'h8);
        wait_disp("R10 recovered", 3);
        tick(1);
        pulse_nq(1'b1);
        chk("R7 error keeps bit", ci_o, 32'h8);
        chk("R7 tag after error", nq_tag_o, 63);
        no_disp("R10 after nq error", 6);

        // R8 queued accept with error
        write_start(1'b0);
        write_start(1'b1);
        eng_queued = 1'b1;
        tf_err = 1'b1;
        pulse_ci(32'h20);
        wait_disp("R5 slot five", 5);
        tick(1);
        tf_err = 1'b0;
        chk("R8 error keeps bit", ci_o, 32'h20);
        no_disp("R10 after accept error", 5);

        // R5 ordering over several slots
        write_start(1'b0);
        write_start(1'b1);
        pulse_ci(32'hA000_0040);
        wait_disp("R5 order first", 6);
        tick(1);
        wait_disp("R5 order second", 29);
        tick(1);
        wait_disp("R5 order third", 31);
        tick(1);
        chk("R8 all accepted", ci_o, 0);

        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog R10 act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule